// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block turns a virtual address into a physical page base by walking a radix page table held in memory. A walk begins with a one-cycle start pulse. The pulse carries the virtual address, the access kind, a supervisor flag, the root table base, the memory size and a translation mode. The walker then reads one table entry per level through a request/response read port. Each entry is either a pointer to the next table or a leaf mapping. The walk ends with a one-cycle done pulse, together with either a physical page base or a fault flag.

Three geometries share the same state machine:

- a 32-bit space with two levels, 10 index bits per level and 4-byte entries;
- a 39-bit space with three levels, 9 index bits per level and 8-byte entries;
- a 48-bit space with four levels, 9 index bits per level and 8-byte entries.

On a permitted leaf the walker writes the referenced bit back into the low 32-bit word of the entry, and also the dirty bit for stores. A leaf found above the last level maps a superpage. In that case the low virtual page-number bits are merged into the physical page number.

The block holds no translation cache. A cache in front of it issues a walk on a miss and keeps the returned page base.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `fault`, `busy`, `rd_req` and `wr_en` are low and `pbase` is zero.
- R2: Mode encoding:
  - `mode` 1 selects two levels of 10 index bits with 4-byte entries.
  - `mode` 2 selects three levels of 9 bits with 8-byte entries.
  - `mode` 3 selects four levels of 9 bits with 8-byte entries.

  The walk starts at `root` with the highest index field. Each entry is read at the current base plus index times entry size, so a successful walk issues exactly one read per level visited.
- R3: `mode` 0 is unsupported. Starting a walk with it gives a done pulse with `fault` set and issues no read.
- R4: The virtual-address width is 12 plus levels times index bits. If any bit from XLEN-1 down to width-1 differs from bit XLEN-1, the walk faults without any read.
- R5: An entry address at or above `mem_size` ends the walk in a fault without issuing that read.
- R6: Entry format:
  - bit0 valid, bit1 readable, bit2 writable, bit3 executable, bit4 user;
  - bit6 referenced, bit7 dirty;
  - the page number is the entry shifted right by 10.

  A valid entry with bits 1..3 clear is a pointer, and the next base is its page number shifted left by 12. With 4-byte entries only `rd_data[31:0]` is used.
- R7: An invalid entry (bit0 clear) faults. A pointer read at the last level also faults.
- R8: Access and permission rules for a leaf:
  - `acc` 2 is a fetch and needs bit3.
  - `acc` 1 is a store and needs bit2.
  - `acc` 0 or 3 is a load and needs bit1.
  - With `sup` low the leaf also needs bit4.

  A leaf that fails these rules faults with no write.
- R9: A permitted leaf causes exactly one write. `wr_addr` is the entry address. `wr_data` is the entry's low word with bit6 set, and bit7 also set for a store. The write happens in the same cycle as the done pulse.
- R10: For a leaf found at level L (counted from 0 at the last level), the low L times index bits of the virtual page number are ORed into the page number. The page base is that result shifted left by 12.
- R11: A composed page base at or above `mem_size` faults. The status-bit write of R9 still takes place.
- R12: `done` is a one-cycle pulse, and `pbase` is zero whenever `fault` is set. `busy` is high from the accepted start until done. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| mode | input | 2 | Translation geometry select |
| vaddr | input | XLEN | Virtual address |
| acc | input | 2 | Access kind: 0/3 load, 1 store, 2 fetch |
| sup | input | 1 | Supervisor access |
| root | input | XLEN | Root table base |
| mem_size | input | XLEN | Size of physical memory in bytes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished pulse |
| fault | output | 1 | Walk ended in a fault |
| pbase | output | XLEN | Physical page base |
| rd_req | output | 1 | Entry read request pulse |
| rd_addr | output | XLEN | Entry read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 64 | Read response entry |
| wr_en | output | 1 | Status-bit write strobe |
| wr_addr | output | XLEN | Status-bit write address |
| wr_data | output | 32 | Low entry word with status bits set |

## Verification
The bench aims at corner cases where a wrong walker still produces plausible results:

- **Sign-extended upper half.** An address with its upper bits set must index the upper half of the root table. A walker that only tests the upper bits for zero would fault here.
- **Garbage in the upper word of 4-byte entries.** The upper word of such an entry holds junk. A walker that fails to mask it computes an out-of-range page and faults.
- **Superpages.** Superpage leaves are placed at the top of the 32-bit mode and in the middle of the 39-bit mode. Dropping the page-number merge shows up as a wrong page base.
- **Write-back before the range check.** A leaf whose page lies beyond memory must still write its status bits. A design that orders this differently either loses that write or returns a base where a fault is due.
- **Read counts.** The bench counts reads per walk. A walk that skips or repeats a level, or reads past an out-of-range entry address, gives a wrong count.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int XLEN   = 64,
  parameter int PG     = 12,
  parameter int PPN_SH = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] vaddr,
  input  logic [1:0]      acc,
  input  logic            sup,
  input  logic [XLEN-1:0] root,
  input  logic [XLEN-1:0] mem_size,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [XLEN-1:0] pbase,
  output logic            rd_req,
  output logic [XLEN-1:0] rd_addr,
  input  logic            rd_valid,
  input  logic [63:0]     rd_data,
  output logic            wr_en,
  output logic [XLEN-1:0] wr_addr,
  output logic [31:0]     wr_data
);

  localparam logic [1:0] ACC_ST = 2'd1;
  localparam logic [1:0] ACC_FE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT} st_t;
  st_t st;

  logic [1:0]      mode_q, acc_q, lvl_q;
  logic            sup_q;
  logic [XLEN-1:0] va_q, base_q, msz_q;

  logic [1:0] mode_sel;
  logic [2:0] lv;
  logic [3:0] ib;
  logic       e8;

  assign mode_sel = (st == S_IDLE) ? mode : mode_q;

  always_comb begin
    case (mode_sel)
      2'd1:    begin lv = 3'd2; ib = 4'd10; e8 = 1'b0; end
      2'd2:    begin lv = 3'd3; ib = 4'd9;  e8 = 1'b1; end
      2'd3:    begin lv = 3'd4; ib = 4'd9;  e8 = 1'b1; end
      default: begin lv = 3'd0; ib = 4'd0;  e8 = 1'b0; end
    endcase
  end

  logic [6:0] va_bits;
  logic       canon_ok;
  assign va_bits = 7'(PG) + 7'(lv) * 7'(ib);

  always_comb begin
    canon_ok = 1'b1;
    for (int i = 0; i < XLEN; i++)
      if (i >= int'(va_bits) - 1 && vaddr[i] != vaddr[XLEN-1]) canon_ok = 1'b0;
  end

  logic [6:0]      sh, sp_bits;
  logic [XLEN-1:0] idx, pte_addr, pte, ppn, sp_mask, phys;
  logic            addr_ok, v_b, r_b, w_b, x_b, u_b, is_leaf, is_ptr, perm_ok;

  assign sh       = 7'(PG) + 7'(lvl_q) * 7'(ib);
  assign idx      = (va_q >> sh) & ((XLEN'(1) << ib) - XLEN'(1));
  assign pte_addr = base_q + (e8 ? (idx << 3) : (idx << 2));
  assign addr_ok  = pte_addr < msz_q;

  assign pte = e8 ? XLEN'(rd_data) : XLEN'(rd_data[31:0]);
  assign ppn = pte >> PPN_SH;
  assign v_b = pte[0];
  assign r_b = pte[1];
  assign w_b = pte[2];
  assign x_b = pte[3];
  assign u_b = pte[4];
  assign is_leaf = v_b && (r_b || w_b || x_b);
  assign is_ptr  = v_b && !(r_b || w_b || x_b);
  assign perm_ok = (acc_q == ACC_FE ? x_b : acc_q == ACC_ST ? w_b : r_b) && (sup_q || u_b);

  assign sp_bits = 7'(lvl_q) * 7'(ib);
  assign sp_mask = (XLEN'(1) << sp_bits) - XLEN'(1);
  assign phys    = (ppn | ((va_q >> PG) & sp_mask)) << PG;

  assign busy    = st != S_IDLE;
  assign rd_req  = (st == S_LOOK) && addr_ok;
  assign rd_addr = pte_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_q <= '0; acc_q <= '0; lvl_q <= '0; sup_q <= 1'b0;
      va_q <= '0; base_q <= '0; msz_q <= '0;
      done <= 1'b0; fault <= 1'b0; pbase <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (lv == 3'd0 || !canon_ok) begin
            done <= 1'b1; fault <= 1'b1; pbase <= '0;
          end else begin
            mode_q <= mode; va_q <= vaddr; acc_q <= acc; sup_q <= sup;
            base_q <= root; msz_q <= mem_size;
            lvl_q  <= 2'(lv - 3'd1);
            st     <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (addr_ok) st <= S_WAIT;
          else begin
            done <= 1'b1; fault <= 1'b1; pbase <= '0; st <= S_IDLE;
          end
        end
        S_WAIT: if (rd_valid) begin
          if (is_ptr && lvl_q != 2'd0) begin
            base_q <= ppn << PG;
            lvl_q  <= lvl_q - 2'd1;
            st     <= S_LOOK;
          end else if (is_leaf && perm_ok) begin
            wr_en   <= 1'b1;
            wr_addr <= pte_addr;
            wr_data <= pte[31:0] | 32'h40 | ((acc_q == ACC_ST) ? 32'h80 : 32'h0);
            done    <= 1'b1;
            fault   <= phys >= msz_q;
            pbase   <= (phys >= msz_q) ? '0 : phys;
            st      <= S_IDLE;
          end else begin
            done <= 1'b1; fault <= 1'b1; pbase <= '0; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done && wr_data[6]);
  a_r9_store_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && acc_q == ACC_ST |-> wr_data[7]);
  a_r12_fault_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> pbase == '0);
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_one_read_per_level: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req && busy);
  a_r5_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr < msz_q);

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0, acc = '0;
  logic sup = 1'b0;
  logic [63:0] vaddr = '0, root = '0, mem_size = 64'h100_0000;
  logic busy, done, fault, rd_req, rd_valid = 1'b0, wr_en;
  logic [63:0] pbase, rd_addr, rd_data = '0, wr_addr;
  logic [31:0] wr_data;

  always #4 clk = ~clk;

  pt_walker uut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vaddr(vaddr),
    .acc(acc), .sup(sup), .root(root), .mem_size(mem_size), .busy(busy), .done(done),
    .fault(fault), .pbase(pbase), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  logic [63:0] mem [logic [63:0]];
  logic pend = 1'b0;
  logic [63:0] pend_addr = '0;
  int rd_cnt = 0;
  int nchk = 0, nfail = 0;

  always @(negedge clk) begin
    rd_valid <= 1'b0;
    if (pend) begin
      rd_valid <= 1'b1;
      rd_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
      pend     <= 1'b0;
    end
    if (rd_req) begin
      pend <= 1'b1;
      pend_addr <= rd_addr;
    end
  end

  always @(posedge clk) if (rd_req) rd_cnt <= rd_cnt + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  m;
    logic [63:0] va;
    logic [1:0]  a;
    logic        s;
    logic        f;
    logic [63:0] pb;
    logic [2:0]  nr;
    logic        w;
    logic [63:0] wa;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  2'd2, 64'h402000, 2'd0, 1'b0, 1'b0, 64'h345000, 3'd3, 1'b1, 64'h12010, 32'hD145F},   // R2 load
    '{4'd9,  2'd2, 64'h402000, 2'd1, 1'b1, 1'b0, 64'h345000, 3'd3, 1'b1, 64'h12010, 32'hD14DF},   // R9 dirty
    '{4'd8,  2'd2, 64'h402000, 2'd2, 1'b0, 1'b0, 64'h345000, 3'd3, 1'b1, 64'h12010, 32'hD145F},   // R8 fetch
    '{4'd8,  2'd2, 64'h403000, 2'd0, 1'b0, 1'b0, 64'h346000, 3'd3, 1'b1, 64'h12018, 32'hD1853},   // R8 read-only load
    '{4'd8,  2'd2, 64'h403000, 2'd1, 1'b0, 1'b1, 64'h0,      3'd3, 1'b0, 64'h0,     32'h0},       // R8 no W
    '{4'd8,  2'd2, 64'h403000, 2'd2, 1'b1, 1'b1, 64'h0,      3'd3, 1'b0, 64'h0,     32'h0},       // R8 no X
    '{4'd8,  2'd2, 64'h404000, 2'd0, 1'b0, 1'b1, 64'h0,      3'd3, 1'b0, 64'h0,     32'h0},       // R8 user vs sup page
    '{4'd8,  2'd2, 64'h404000, 2'd0, 1'b1, 1'b0, 64'h347000, 3'd3, 1'b1, 64'h12020, 32'hD1C4F},   // R8 sup ok
    '{4'd10, 2'd2, 64'h605000, 2'd0, 1'b0, 1'b0, 64'h405000, 3'd2, 1'b1, 64'h11018, 32'h10005F},  // R10 2 MiB
    '{4'd7,  2'd2, 64'h800000, 2'd0, 1'b0, 1'b1, 64'h0,      3'd2, 1'b0, 64'h0,     32'h0},       // R7 invalid
    '{4'd4,  2'd2, 64'h80_0000_0000, 2'd0, 1'b0, 1'b1, 64'h0, 3'd0, 1'b0, 64'h0,   32'h0},       // R4 noncanon
    '{4'd4,  2'd2, 64'hFFFF_FFC0_0040_2000, 2'd0, 1'b0, 1'b0, 64'h345000, 3'd3, 1'b1, 64'h12010, 32'hD145F}, // R4 high half
    '{4'd5,  2'd2, 64'h4000_0000, 2'd0, 1'b0, 1'b1, 64'h0,   3'd1, 1'b0, 64'h0,     32'h0},       // R5 table beyond memory
    '{4'd11, 2'd2, 64'h405000, 2'd0, 1'b0, 1'b1, 64'h0,      3'd3, 1'b1, 64'h12028, 32'h48D05F},  // R11 page beyond memory
    '{4'd7,  2'd2, 64'h406000, 2'd0, 1'b0, 1'b1, 64'h0,      3'd3, 1'b0, 64'h0,     32'h0},       // R7 pointer at last level
    '{4'd3,  2'd0, 64'h402000, 2'd0, 1'b0, 1'b1, 64'h0,      3'd0, 1'b0, 64'h0,     32'h0},       // R3 mode 0
    '{4'd6,  2'd1, 64'h803000, 2'd0, 1'b0, 1'b0, 64'h500000, 3'd2, 1'b1, 64'h2100C, 32'h14005F},  // R6 low word only
    '{4'd10, 2'd1, 64'hC07000, 2'd1, 1'b0, 1'b0, 64'h807000, 3'd1, 1'b1, 64'h2000C, 32'h2000DF},  // R10 4 MiB
    '{4'd4,  2'd1, 64'h8000_0000, 2'd0, 1'b0, 1'b1, 64'h0,   3'd0, 1'b0, 64'h0,     32'h0},       // R4 32-bit
    '{4'd2,  2'd3, 64'h80_4000_1000, 2'd0, 1'b0, 1'b0, 64'h600000, 3'd4, 1'b1, 64'h33008, 32'h18005F}, // R2 four levels
    '{4'd4,  2'd3, 64'h8000_0000_0000, 2'd0, 1'b0, 1'b1, 64'h0, 3'd0, 1'b0, 64'h0, 32'h0},        // R4 48-bit
    '{4'd4,  2'd2, 64'h80_4000_1000, 2'd0, 1'b0, 1'b1, 64'h0, 3'd0, 1'b0, 64'h0,   32'h0},       // R4 mode width
    '{4'd8,  2'd2, 64'h403000, 2'd3, 1'b0, 1'b0, 64'h346000, 3'd3, 1'b1, 64'h12018, 32'hD1853}    // R8 acc 3 is load
  };

  logic        r_f, r_w;
  logic [63:0] r_pb, r_wa;
  logic [31:0] r_wd;
  int          r_nr, r_dn;

  task automatic walk(input logic [1:0] m, input logic [63:0] va, input logic [1:0] a,
                      input logic s, input logic poke);
    @(negedge clk);
    rd_cnt = 0;
    mode = m; vaddr = va; acc = a; sup = s;
    root = (m == 2'd1) ? 64'h20000 : (m == 2'd3) ? 64'h30000 : 64'h10000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      mode = 2'd0; vaddr = 64'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    r_dn = 0;
    for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    if (done) begin
      r_dn = 1; r_f = fault; r_pb = pbase; r_w = wr_en; r_wa = wr_addr; r_wd = wr_data;
      r_nr = rd_cnt;
    end else begin
      nchk++; nfail++;
      $display("FAIL R12 walk did not finish actual=0 expected=1");
    end
  endtask

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    mem[64'h10000] = 64'h4401;
    mem[64'h10800] = 64'h4401;
    mem[64'h10008] = 64'h800001;
    mem[64'h11010] = 64'h4801;
    mem[64'h11018] = 64'h10001F;
    mem[64'h12010] = 64'hD141F;
    mem[64'h12018] = 64'hD1813;
    mem[64'h12020] = 64'hD1C0F;
    mem[64'h12028] = 64'h48D01F;
    mem[64'h12030] = 64'h4801;
    mem[64'h20008] = 64'hFFFF_0000_0000_8401;
    mem[64'h2000C] = 64'h20001F;
    mem[64'h2100C] = 64'hDEAD_BEEF_0014_001F;
    mem[64'h30008] = 64'hC401;
    mem[64'h31008] = 64'hC801;
    mem[64'h32000] = 64'hCC01;
    mem[64'h33008] = 64'h18001F;

    repeat (3) @(negedge clk);
    check("R1 done", {63'b0, done}, 64'd0);
    check("R1 busy/rd_req/wr_en/fault", {60'b0, busy, rd_req, wr_en, fault}, 64'd0);
    check("R1 pbase", pbase, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      walk(VEC[i].m, VEC[i].va, VEC[i].a, VEC[i].s, 1'b0);
      if (r_dn == 1) begin
        check($sformatf("R%0d fault v%0d", VEC[i].rq, i), {63'b0, r_f}, {63'b0, VEC[i].f});
        check($sformatf("R%0d pbase v%0d", VEC[i].rq, i), r_pb, VEC[i].pb);
        check($sformatf("R%0d reads v%0d", VEC[i].rq, i), 64'(r_nr), 64'(VEC[i].nr));
        check($sformatf("R%0d write v%0d", VEC[i].rq, i), {63'b0, r_w}, {63'b0, VEC[i].w});
        if (VEC[i].w) begin
          check($sformatf("R9 wr_addr v%0d", i), r_wa, VEC[i].wa);
          check($sformatf("R9 wr_data v%0d", i), {32'b0, r_wd}, {32'b0, VEC[i].wd});
        end
      end
      @(negedge clk);
      check($sformatf("R12 done pulse v%0d", i), {63'b0, done}, 64'd0);
    end

    // R12: start while busy is ignored
    @(negedge clk);
    rd_cnt = 0;
    mode = 2'd2; vaddr = 64'h402000; acc = 2'd0; sup = 1'b0; root = 64'h10000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R12 busy after start", {63'b0, busy}, 64'd1);
    mode = 2'd0; vaddr = 64'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R12 busy start ignored, no early done", {63'b0, done}, 64'd0);
    r_dn = 0;
    for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    check("R12 busy walk done", {63'b0, done}, 64'd1);
    check("R12 busy walk fault", {63'b0, fault}, 64'd0);
    check("R12 busy walk pbase", pbase, 64'h345000);
    check("R12 busy walk reads", 64'(rd_cnt), 64'd3);
    @(negedge clk);
    check("R12 busy low after done", {63'b0, busy}, 64'd0);
    begin
      int extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R12 no second done", 64'(extra), 64'd0);
    end

    // R5: small memory makes the root entry itself out of range
    mem_size = 64'h10000;
    walk(2'd2, 64'h402000, 2'd0, 1'b0, 1'b0);
    if (r_dn == 1) begin
      check("R5 root beyond memory fault", {63'b0, r_f}, 64'd1);
      check("R5 root beyond memory reads", 64'(r_nr), 64'd0);
    end
    mem_size = 64'h100_0000;

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule